// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves a microcontroller between four power modes and decides when it returns to full operation. Software writes a two-bit mode value together with two retention bits for the external RAM banks. From the registered mode, the block drives clock enables for the CPU, the peripherals and the always-on logic (GPIO and system controller). It also drives power enables for the internal RAM, each external RAM bank and a small scratch area, plus a transceiver shutdown line.

Each low-power mode has its own exit rule. The light mode stops only the CPU and ends on any enabled interrupt. The medium mode keeps the always-on logic alive and ends only on a GPIO or system-controller wake. The deepest mode leaves only the scratch area powered and ends only when a dedicated active-low pin is pulled down. On leaving either of the two deeper modes, a reset pulse of fixed length goes to the domains that lost their contents. On leaving the deepest mode, the bank retention bits are also cleared.

Top module: `lpm_ctrl`

## Requirements
- R1: Mode encoding on `mode` and `wr_mode`: 00 RUNNING, 01 STANDBY, 10 SLEEP, 11 DEEPSLEEP. A write (`wr_en` high) that is accepted loads `wr_mode` into `mode` and `wr_keep` into `keep_bits` at the next clock edge.
- R2: In RUNNING, every clock and power enable is 1 and `radio_off` is 0.
- R3: In STANDBY, `cpu_clk_en` is 0. All other clock and power enables are 1 and `radio_off` is 0.
- R4: In STANDBY, any bit set in both `irq_act` and `irq_en` returns `mode` to 00 at the next edge. Active interrupts whose enable bit is 0 have no effect.
- R5: In SLEEP, `cpu_clk_en` and `periph_clk_en` are 0. `aon_clk_en`, `iram_pwr` and `scratch_pwr` are 1, `radio_off` is 0, and `xram_pwr[i]` equals `keep_bits[i]`.
- R6: In SLEEP, only `gpio_wake` or `sysc_wake` returns `mode` to 00 at the next edge. Masked-in interrupts and a low wake pin are ignored.
- R7: In DEEPSLEEP, every clock enable and every RAM power enable is 0 except `scratch_pwr`, which is 1, and `radio_off` is 1.
- R8: In DEEPSLEEP, only `wake_pin_n` low returns `mode` to 00 at the next edge. Interrupts and both wake requests are ignored.
- R9: Leaving SLEEP or DEEPSLEEP raises `dom_rst` from the first RUNNING cycle for exactly RST_CYC (default 4) cycles. Leaving STANDBY raises no reset.
- R10: Leaving DEEPSLEEP clears `keep_bits` to 00. Leaving SLEEP keeps them.
- R11: A write is accepted only while `mode` is 00 and `dom_rst` is 0. Any other write changes neither `mode` nor `keep_bits`.
- R12: If a mode's wake condition is already true when that mode is entered, `mode` returns to 00 after exactly one cycle in the low-power mode.
- R13: After reset, `mode` is 00, `keep_bits` is 00 and `dom_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe for the mode register |
| wr_mode | input | 2 | Requested mode |
| wr_keep | input | 2 | Retention bits for the external RAM banks in SLEEP |
| irq_act | input | NIRQ | Interrupt lines that are currently active |
| irq_en | input | NIRQ | Interrupt enable mask |
| gpio_wake | input | 1 | Enabled GPIO interrupt is active |
| sysc_wake | input | 1 | Enabled system-controller interrupt (such as the wakeup timer) is active |
| wake_pin_n | input | 1 | Dedicated active-low wake pin |
| mode | output | 2 | Current mode |
| keep_bits | output | 2 | Current bank retention bits |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| aon_clk_en | output | 1 | GPIO and system-controller clock enable |
| iram_pwr | output | 1 | Internal RAM power |
| xram_pwr | output | 2 | External RAM bank power and retention, one bit per bank |
| scratch_pwr | output | 1 | Scratch RAM power |
| radio_off | output | 1 | Transceiver shutdown |
| dom_rst | output | 1 | Reset to the domains that lost power |

## Verification
A write or a wake condition present before a clock edge shows up on `mode` and `keep_bits` right after that edge, and the enables decoded from them change in the same cycle. `dom_rst` rises right after the wake edge and stays high for the next RST_CYC samples. The driver applies stimulus at the falling edge and queues one expected item per rising edge. The monitor samples two nanoseconds after each rising edge and compares against the oldest queued item, so every expectation lands on the exact cycle the requirement names.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        M_RUN   = 2'b00,
        M_STBY  = 2'b01,
        M_SLEEP = 2'b10,
        M_DEEP  = 2'b11
    } pmode_e;

    typedef struct packed {
        pmode_e             mode;
        logic [NBANK-1:0]   keep;
    } lpm_state_t;

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake #(
    parameter int NIRQ = 8
) (
    input  lpm_pkg::pmode_e  mode,
    input  logic [NIRQ-1:0]  irq_act,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic             gpio_wake,
    input  logic             sysc_wake,
    input  logic             wake_pin_n,
    output logic             wake,
    output logic             lost_power
);
    import lpm_pkg::*;

    always_comb begin
        wake       = 1'b0;
        lost_power = 1'b0;
        case (mode)
            M_STBY:  wake = |(irq_act & irq_en);
            M_SLEEP: begin
                wake       = gpio_wake | sysc_wake;
                lost_power = 1'b1;
            end
            M_DEEP:  begin
                wake       = ~wake_pin_n;
                lost_power = 1'b1;
            end
            default: wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/lpm_rstgen.sv
module lpm_rstgen #(
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic dom_rst
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(RST_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign dom_rst = (cnt_q != '0);

endmodule

// File: rtl/lpm_dec.sv
module lpm_dec (
    input  lpm_pkg::pmode_e                 mode,
    input  logic [lpm_pkg::NBANK-1:0]       keep,
    output logic                            cpu_clk_en,
    output logic                            periph_clk_en,
    output logic                            aon_clk_en,
    output logic                            iram_pwr,
    output logic [lpm_pkg::NBANK-1:0]       xram_pwr,
    output logic                            scratch_pwr,
    output logic                            radio_off
);
    import lpm_pkg::*;

    logic is_run, is_stby, is_sleep, is_deep;

    always_comb begin
        is_run   = (mode == M_RUN);
        is_stby  = (mode == M_STBY);
        is_sleep = (mode == M_SLEEP);
        is_deep  = (mode == M_DEEP);
        cpu_clk_en    = is_run;
        periph_clk_en = is_run | is_stby;
        aon_clk_en    = ~is_deep;
        iram_pwr      = ~is_deep;
        scratch_pwr   = 1'b1;
        radio_off     = is_deep;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign xram_pwr[b] = is_run | is_stby | (is_sleep & keep[b]);
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
    parameter int NIRQ    = 8,
    parameter int RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_mode,
    input  logic [1:0]       wr_keep,
    input  logic [NIRQ-1:0]  irq_act,
    input  logic [NIRQ-1:0]  irq_en,
    input  logic             gpio_wake,
    input  logic             sysc_wake,
    input  logic             wake_pin_n,
    output logic [1:0]       mode,
    output logic [1:0]       keep_bits,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             aon_clk_en,
    output logic             iram_pwr,
    output logic [1:0]       xram_pwr,
    output logic             scratch_pwr,
    output logic             radio_off,
    output logic             dom_rst
);
    import lpm_pkg::*;

    lpm_state_t st_d, st_q;
    logic       wake, lost_power, wr_ok, rst_start;

    lpm_wake #(.NIRQ(NIRQ)) u_wake (
        .mode       (st_q.mode),
        .irq_act    (irq_act),
        .irq_en     (irq_en),
        .gpio_wake  (gpio_wake),
        .sysc_wake  (sysc_wake),
        .wake_pin_n (wake_pin_n),
        .wake       (wake),
        .lost_power (lost_power)
    );

    always_comb begin
        st_d      = st_q;
        wr_ok     = wr_en && (st_q.mode == M_RUN) && !dom_rst;
        rst_start = wake && lost_power;
        if (wake) begin
            st_d.mode = M_RUN;
            if (st_q.mode == M_DEEP) begin
                st_d.keep = '0;
            end
        end else if (wr_ok) begin
            st_d.mode = pmode_e'(wr_mode);
            st_d.keep = wr_keep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_RUN, keep: '0};
        end else begin
            st_q <= st_d;
        end
    end

    lpm_rstgen #(.RST_CYC(RST_CYC)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rst_start),
        .dom_rst (dom_rst)
    );

    lpm_dec u_dec (
        .mode          (st_q.mode),
        .keep          (st_q.keep),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .aon_clk_en    (aon_clk_en),
        .iram_pwr      (iram_pwr),
        .xram_pwr      (xram_pwr),
        .scratch_pwr   (scratch_pwr),
        .radio_off     (radio_off)
    );

    assign mode      = st_q.mode;
    assign keep_bits = st_q.keep;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int NIRQ    = 8,
    parameter int RST_CYC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [NIRQ-1:0] irq_act,
    input logic [NIRQ-1:0] irq_en,
    input logic            gpio_wake,
    input logic            sysc_wake,
    input logic            wake_pin_n,
    input logic [1:0]      mode,
    input logic [1:0]      keep_bits,
    input logic            cpu_clk_en,
    input logic            radio_off,
    input logic            dom_rst
);
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
        end else begin
            hi_cnt <= dom_rst ? hi_cnt + 1 : 0;
        end
    end

    p_cpu_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> !cpu_clk_en);

    p_stby_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && |(irq_act & irq_en)) |=> (mode == 2'b00));

    p_sleep_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && (gpio_wake || sysc_wake)) |=> (mode == 2'b00 && dom_rst));

    p_deep_radio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> radio_off);

    p_deep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && wake_pin_n) |=> (mode == 2'b11));

    p_rst_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst) |-> (hi_cnt == RST_CYC));

    p_rst_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dom_rst |-> (mode == 2'b00));

    p_keep_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !wake_pin_n) |=> (keep_bits == 2'b00));

    p_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && wr_en && !(|(irq_act & irq_en))) |=> (mode == 2'b01 && $stable(keep_bits)));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NIRQ(NIRQ), .RST_CYC(RST_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .irq_act    (irq_act),
    .irq_en     (irq_en),
    .gpio_wake  (gpio_wake),
    .sysc_wake  (sysc_wake),
    .wake_pin_n (wake_pin_n),
    .mode       (mode),
    .keep_bits  (keep_bits),
    .cpu_clk_en (cpu_clk_en),
    .radio_off  (radio_off),
    .dom_rst    (dom_rst)
);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
    localparam int NIRQ = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_mode = 2'b00;
    logic [1:0]      wr_keep = 2'b00;
    logic [NIRQ-1:0] irq_act = '0;
    logic [NIRQ-1:0] irq_en = '0;
    logic            gpio_wake = 1'b0;
    logic            sysc_wake = 1'b0;
    logic            wake_pin_n = 1'b1;
    logic [1:0]      mode, keep_bits, xram_pwr;
    logic            cpu_clk_en, periph_clk_en, aon_clk_en, iram_pwr;
    logic            scratch_pwr, radio_off, dom_rst;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [1:0] m;
        logic [1:0] k;
        logic       r;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    lpm_ctrl #(.NIRQ(NIRQ), .RST_CYC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .wr_keep(wr_keep),
        .irq_act(irq_act), .irq_en(irq_en), .gpio_wake(gpio_wake), .sysc_wake(sysc_wake),
        .wake_pin_n(wake_pin_n), .mode(mode), .keep_bits(keep_bits),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .aon_clk_en(aon_clk_en),
        .iram_pwr(iram_pwr), .xram_pwr(xram_pwr), .scratch_pwr(scratch_pwr),
        .radio_off(radio_off), .dom_rst(dom_rst)
    );

    // {cpu, periph, aon, iram, xram[1], xram[0], scratch, radio_off}
    function automatic logic [7:0] exp_outs(input logic [1:0] m, input logic [1:0] k);
        case (m)
            2'b00:   return 8'b1111_1110;
            2'b01:   return 8'b0111_1110;
            2'b10:   return {4'b0011, k, 2'b10};
            default: return 8'b0000_0011;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] outs_now();
        return {cpu_clk_en, periph_clk_en, aon_clk_en, iram_pwr, xram_pwr, scratch_pwr, radio_off};
    endfunction

    // Monitor: compares the oldest expectation 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " mode"}, {6'b0, mode}, {6'b0, e.m});
                chk({e.tag, " keep"}, {6'b0, keep_bits}, {6'b0, e.k});
                chk({e.tag, " dom_rst"}, {7'b0, dom_rst}, {7'b0, e.r});
                chk({e.tag, " enables"}, outs_now(), exp_outs(e.m, e.k));
            end
        end
    end

    // Driver: called just after a falling edge with inputs already set.
    task automatic cyc(input logic [1:0] m, input logic [1:0] k, input logic r, input string tag);
        exp_t e;
        e.m = m; e.k = k; e.r = r; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; irq_act = '0; irq_en = '0;
        gpio_wake = 1'b0; sysc_wake = 1'b0; wake_pin_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] m, input logic [1:0] k);
        wr_en = 1'b1; wr_mode = m; wr_keep = k;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R13 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 mode", {6'b0, mode}, 8'h00);
        chk("R13 keep", {6'b0, keep_bits}, 8'h00);
        chk("R13 dom_rst", {7'b0, dom_rst}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(2'b00, 2'b00, 1'b0, "R2 running");

        // R1 R3 R4 R11: standby
        wr(2'b01, 2'b00);
        cyc(2'b01, 2'b00, 1'b0, "R1 R3 enter standby");
        idle(); irq_act = 8'h01;
        cyc(2'b01, 2'b00, 1'b0, "R4 masked irq ignored");
        wr(2'b00, 2'b11);
        cyc(2'b01, 2'b00, 1'b0, "R11 write in standby ignored");
        idle(); irq_act = 8'h81; irq_en = 8'h80;
        cyc(2'b00, 2'b00, 1'b0, "R4 enabled irq wakes");
        idle();
        cyc(2'b00, 2'b00, 1'b0, "R9 no reset after standby");

        // R5 R6 R9 R10 R11: sleep, bank 0 kept
        wr(2'b10, 2'b01);
        cyc(2'b10, 2'b01, 1'b0, "R5 enter sleep");
        idle(); irq_act = 8'hFF; irq_en = 8'hFF;
        cyc(2'b10, 2'b01, 1'b0, "R6 plain irq ignored");
        idle(); wake_pin_n = 1'b0;
        cyc(2'b10, 2'b01, 1'b0, "R6 wake pin ignored");
        idle(); sysc_wake = 1'b1;
        cyc(2'b00, 2'b01, 1'b1, "R6 R9 R10 sysc wake");
        idle(); wr(2'b11, 2'b10);
        cyc(2'b00, 2'b01, 1'b1, "R11 write during reset ignored");
        idle();
        cyc(2'b00, 2'b01, 1'b1, "R9 pulse 3");
        cyc(2'b00, 2'b01, 1'b1, "R9 pulse 4");
        cyc(2'b00, 2'b01, 1'b0, "R9 pulse ends");

        // R5 R6: sleep, bank 1 kept, GPIO wake
        wr(2'b10, 2'b10);
        cyc(2'b10, 2'b10, 1'b0, "R5 sleep bank1");
        idle(); gpio_wake = 1'b1;
        cyc(2'b00, 2'b10, 1'b1, "R6 gpio wake");
        idle();
        for (int i = 0; i < 3; i++) cyc(2'b00, 2'b10, 1'b1, "R9 pulse gpio");
        cyc(2'b00, 2'b10, 1'b0, "R9 pulse gpio ends");

        // R7 R8 R10: deepsleep
        wr(2'b11, 2'b11);
        cyc(2'b11, 2'b11, 1'b0, "R7 enter deepsleep");
        idle(); irq_act = 8'hFF; irq_en = 8'hFF; gpio_wake = 1'b1; sysc_wake = 1'b1;
        cyc(2'b11, 2'b11, 1'b0, "R8 interrupts ignored");
        idle(); wake_pin_n = 1'b0;
        cyc(2'b00, 2'b00, 1'b1, "R8 R10 pin wake clears keep");
        idle();
        for (int i = 0; i < 3; i++) cyc(2'b00, 2'b00, 1'b1, "R9 pulse deep");
        cyc(2'b00, 2'b00, 1'b0, "R9 pulse deep ends");

        // R12: wake conditions already present at entry
        wake_pin_n = 1'b0; wr(2'b11, 2'b01);
        cyc(2'b11, 2'b01, 1'b0, "R12 deep entered");
        wr_en = 1'b0;
        cyc(2'b00, 2'b00, 1'b1, "R12 deep immediate return");
        idle();
        for (int i = 0; i < 3; i++) cyc(2'b00, 2'b00, 1'b1, "R12 pulse");
        cyc(2'b00, 2'b00, 1'b0, "R12 pulse ends");
        irq_act = 8'h04; irq_en = 8'h04; wr(2'b01, 2'b10);
        cyc(2'b01, 2'b10, 1'b0, "R12 standby entered");
        wr_en = 1'b0;
        cyc(2'b00, 2'b10, 1'b0, "R12 standby immediate return");
        idle(); gpio_wake = 1'b1; wr(2'b10, 2'b11);
        cyc(2'b10, 2'b11, 1'b0, "R12 sleep entered");
        wr_en = 1'b0;
        cyc(2'b00, 2'b11, 1'b1, "R12 sleep immediate return");
        idle();

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule